// File: doc/BRIEF.md
# Serial Channel Interrupt and Transfer Trigger Unit

This unit sits beside one serial channel and converts its status events into interrupt requests for the CPU and trigger lines for a data transfer controller. It holds six status flags (transmit buffer empty, transmit complete, receive buffer full, overrun, parity error, framing error). The channel sets them with one-cycle set pulses. Software clears them with a strobe and a bit mask, and the transfer controller clears them by reporting a finished transfer.

Four request lines leave the unit independently: receive error, receive full, transmit empty and transmit complete. Each line is the registered AND of its flag and its enable. A summary vector marks the single highest-priority active request. Only the receive-full and transmit-empty sources can be routed to the transfer controller instead of the CPU. A per-source select bit does this routing. When a routed transfer completes, the flag that caused it is cleared. Clearing the transmit-empty flag always clears the transmit-complete flag in the same cycle.

Top module: `sci_irq_unit`

## Requirements
- R1: After reset the flags port reads 6'b000011, and every request, trigger and summary output is 0.
- R2: The flags port uses these bit positions: bit0 transmit empty, bit1 transmit complete, bit2 receive full, bit3 overrun, bit4 parity error, bit5 framing error. A set pulse on a flag's input makes that bit 1 after the next rising edge.
- R3: One edge after the flags show it, req_rx_err is 1 exactly when at least one of flags[5:3] is 1 and en_rx is 1. This source never drives a trigger.
- R4: One edge after the flags show it, req_rx_full is flags[2] AND en_rx AND NOT sel_rx. Likewise, req_tx_empty is flags[0] AND en_tx AND NOT sel_tx.
- R5: One edge after the flags show it, req_tx_end is flags[1] AND en_txend. This source never drives a trigger.
- R6: trig_rx is registered flags[2] AND en_rx AND sel_rx. trig_tx is registered flags[0] AND en_tx AND sel_tx. A trigger and its CPU request are never 1 together.
- R7: xfer_done_rx sampled while trig_rx is 1 clears flags[2]. xfer_done_tx sampled while trig_tx is 1 clears flags[0] and flags[1] in the same edge.
- R8: When sw_clr_stb is 1, every flag whose sw_clr_mask bit is 1 clears. Clearing bit0 this way also clears bit1.
- R9: A set pulse for a flag wins over any clear of that flag in the same cycle.
- R10: prio_vec is one-hot over the active requests and marks the highest one. The order is bit3 rx error, then bit2 rx full, then bit1 tx empty, then bit0 tx complete. prio_vec is 0 when no request is active.
- R11: A done pulse sampled while the matching trigger is 0 has no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_tx_empty | input | 1 | Set pulse for the transmit-empty flag |
| set_tx_end | input | 1 | Set pulse for the transmit-complete flag |
| set_rx_full | input | 1 | Set pulse for the receive-full flag |
| set_overrun | input | 1 | Set pulse for the overrun flag |
| set_parity | input | 1 | Set pulse for the parity-error flag |
| set_framing | input | 1 | Set pulse for the framing-error flag |
| sw_clr_stb | input | 1 | Software clear strobe |
| sw_clr_mask | input | 6 | Flags to clear, same bit order as flags |
| en_tx | input | 1 | Transmit-empty enable |
| en_rx | input | 1 | Receive-full and receive-error enable |
| en_txend | input | 1 | Transmit-complete enable |
| sel_tx | input | 1 | Route transmit-empty to the transfer controller |
| sel_rx | input | 1 | Route receive-full to the transfer controller |
| xfer_done_tx | input | 1 | Transfer controller finished a transmit-side transfer |
| xfer_done_rx | input | 1 | Transfer controller finished a receive-side transfer |
| flags | output | 6 | Status flag register |
| req_rx_err | output | 1 | Receive error request |
| req_rx_full | output | 1 | Receive full request |
| req_tx_empty | output | 1 | Transmit empty request |
| req_tx_end | output | 1 | Transmit complete request |
| trig_rx | output | 1 | Transfer trigger for the receive side |
| trig_tx | output | 1 | Transfer trigger for the transmit side |
| prio_vec | output | 4 | One-hot highest pending request |

## Verification
A flag register holding a wrong value shows on the flags port after the edge that caused it. It also reaches the matching request or trigger one edge later. An error in the request registers shows on the request pins and on prio_vec within one cycle, because prio_vec is decoded from them without delay. The bench keeps a cycle-accurate model of flags, requests and triggers. It compares every output after every edge, so a mistake is caught in the cycle it first appears.

// File: rtl/sci_irq_unit.sv
module sci_irq_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_tx_empty,
  input  logic       set_tx_end,
  input  logic       set_rx_full,
  input  logic       set_overrun,
  input  logic       set_parity,
  input  logic       set_framing,
  input  logic       sw_clr_stb,
  input  logic [5:0] sw_clr_mask,
  input  logic       en_tx,
  input  logic       en_rx,
  input  logic       en_txend,
  input  logic       sel_tx,
  input  logic       sel_rx,
  input  logic       xfer_done_tx,
  input  logic       xfer_done_rx,
  output logic [5:0] flags,
  output logic       req_rx_err,
  output logic       req_rx_full,
  output logic       req_tx_empty,
  output logic       req_tx_end,
  output logic       trig_rx,
  output logic       trig_tx,
  output logic [3:0] prio_vec
);

  localparam logic [5:0] FLAG_RST = 6'b000011;

  logic [5:0] flag_q, set_v, clr_v, sw_v, flag_d;
  logic       done_tx_ok, done_rx_ok;

  assign set_v = {set_framing, set_parity, set_overrun, set_rx_full, set_tx_end, set_tx_empty};
  assign sw_v  = sw_clr_stb ? sw_clr_mask : 6'b0;
  assign done_tx_ok = xfer_done_tx & trig_tx;
  assign done_rx_ok = xfer_done_rx & trig_rx;

  assign clr_v[0]   = sw_v[0] | done_tx_ok;
  assign clr_v[1]   = sw_v[1] | clr_v[0];
  assign clr_v[2]   = sw_v[2] | done_rx_ok;
  assign clr_v[5:3] = sw_v[5:3];

  assign flag_d = (flag_q & ~clr_v) | set_v;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= FLAG_RST;
    else        flag_q <= flag_d;

  assign flags = flag_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_rx_err   <= 1'b0;
      req_rx_full  <= 1'b0;
      req_tx_empty <= 1'b0;
      req_tx_end   <= 1'b0;
      trig_rx      <= 1'b0;
      trig_tx      <= 1'b0;
    end else begin
      req_rx_err   <= (|flag_q[5:3]) & en_rx;
      req_rx_full  <= flag_q[2] & en_rx & ~sel_rx;
      trig_rx      <= flag_q[2] & en_rx & sel_rx;
      req_tx_empty <= flag_q[0] & en_tx & ~sel_tx;
      trig_tx      <= flag_q[0] & en_tx & sel_tx;
      req_tx_end   <= flag_q[1] & en_txend;
    end

  always_comb begin
    prio_vec = 4'b0000;
    if      (req_rx_err)   prio_vec = 4'b1000;
    else if (req_rx_full)  prio_vec = 4'b0100;
    else if (req_tx_empty) prio_vec = 4'b0010;
    else if (req_tx_end)   prio_vec = 4'b0001;
  end

  a_r6_req_trig_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(trig_tx && req_tx_empty) && !(trig_rx && req_rx_full));

  a_r10_prio_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(prio_vec) && ((|prio_vec) == (req_rx_err | req_rx_full | req_tx_empty | req_tx_end)));

  a_r7_tx_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_tx && xfer_done_tx && !set_tx_empty && !set_tx_end) |=> (flags[1:0] == 2'b00));

  a_r7_rx_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_rx && xfer_done_rx && !set_rx_full) |=> !flags[2]);

  a_r5_txend_gated: assert property (@(posedge clk) disable iff (!rst_n)
    req_tx_end |-> $past(en_txend));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_rx_full |=> flags[2]);

endmodule

// File: tb/sci_irq_unit_test.sv
`timescale 1ns/1ps
module sci_irq_unit_test;
  logic clk = 0, rst_n = 0;
  logic s_txe, s_txend, s_rxf, s_ovr, s_par, s_frm, clr_stb, e_tx, e_rx, e_te, sl_tx, sl_rx, d_tx, d_rx;
  logic [5:0] clr_mask;
  logic [5:0] flags;
  logic r_err, r_full, r_txe, r_te, t_rx, t_tx;
  logic [3:0] prio;
  int n_tests = 0, n_fail = 0;
  logic [5:0] m_flag;
  logic [3:0] m_req;
  logic [1:0] m_trig;

  always #4 clk = ~clk;

  sci_irq_unit uut (
    .clk(clk), .rst_n(rst_n),
    .set_tx_empty(s_txe), .set_tx_end(s_txend), .set_rx_full(s_rxf),
    .set_overrun(s_ovr), .set_parity(s_par), .set_framing(s_frm),
    .sw_clr_stb(clr_stb), .sw_clr_mask(clr_mask),
    .en_tx(e_tx), .en_rx(e_rx), .en_txend(e_te),
    .sel_tx(sl_tx), .sel_rx(sl_rx),
    .xfer_done_tx(d_tx), .xfer_done_rx(d_rx),
    .flags(flags), .req_rx_err(r_err), .req_rx_full(r_full),
    .req_tx_empty(r_txe), .req_tx_end(r_te),
    .trig_rx(t_rx), .trig_tx(t_tx), .prio_vec(prio)
  );

  function automatic logic [3:0] exp_prio(input logic [3:0] q);
    if (q[3]) return 4'b1000;
    if (q[2]) return 4'b0100;
    if (q[1]) return 4'b0010;
    if (q[0]) return 4'b0001;
    return 4'b0000;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    {s_txe, s_txend, s_rxf, s_ovr, s_par, s_frm, clr_stb, d_tx, d_rx} = '0;
    clr_mask = '0;
  endtask

  task automatic step();
    logic [5:0] sw, clr, setv, nf;
    logic [3:0] nq;
    logic [1:0] nt;
    sw = clr_stb ? clr_mask : 6'b0;
    clr[0] = sw[0] | (d_tx & m_trig[0]);
    clr[1] = sw[1] | clr[0];
    clr[2] = sw[2] | (d_rx & m_trig[1]);
    clr[5:3] = sw[5:3];
    setv = {s_frm, s_par, s_ovr, s_rxf, s_txend, s_txe};
    nf = (m_flag & ~clr) | setv;
    nq = {(|m_flag[5:3]) & e_rx, m_flag[2] & e_rx & ~sl_rx, m_flag[0] & e_tx & ~sl_tx, m_flag[1] & e_te};
    nt = {m_flag[2] & e_rx & sl_rx, m_flag[0] & e_tx & sl_tx};
    m_flag = nf; m_req = nq; m_trig = nt;
    @(posedge clk); #1;
    chk("R2/R7/R8/R9 flags", {2'b0, flags}, {2'b0, m_flag});
    chk("R3 req_rx_err", {7'b0, r_err}, {7'b0, m_req[3]});
    chk("R4 req_rx_full", {7'b0, r_full}, {7'b0, m_req[2]});
    chk("R4 req_tx_empty", {7'b0, r_txe}, {7'b0, m_req[1]});
    chk("R5 req_tx_end", {7'b0, r_te}, {7'b0, m_req[0]});
    chk("R6 triggers", {6'b0, t_rx, t_tx}, {6'b0, m_trig});
    chk("R10 prio_vec", {4'b0, prio}, {4'b0, exp_prio({r_err, r_full, r_txe, r_te})});
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    process::self().srandom(32'h5C1);
    idle_inputs();
    {e_tx, e_rx, e_te, sl_tx, sl_rx} = '0;
    m_flag = 6'b000011; m_req = '0; m_trig = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 flags", {2'b0, flags}, 8'h03);
    chk("R1 outputs", {r_err, r_full, r_txe, r_te, t_rx, t_tx, 2'b0}, 8'h00);
    chk("R1 prio", {4'b0, prio}, 8'h00);

    // R5 transmit complete request with only its enable
    e_te = 1; step(); step();
    chk("R5 tx_end request", {7'b0, r_te}, 8'h01);
    // R8 clearing tx empty by software also clears tx end
    clr_stb = 1; clr_mask = 6'b000001; step();
    chk("R8 sw clear bit0 drags bit1", {2'b0, flags}, 8'h00);
    // R9 set beats clear
    s_rxf = 1; clr_stb = 1; clr_mask = 6'b000100; step();
    chk("R9 set wins", {7'b0, flags[2]}, 8'h01);
    // R11 done without trigger ignored
    d_rx = 1; step();
    chk("R11 done ignored", {7'b0, flags[2]}, 8'h01);
    // R6 routed trigger, then R7 done clears
    e_rx = 1; sl_rx = 1; step(); step();
    chk("R6 trig_rx", {6'b0, t_rx, r_full}, 8'h02);
    d_rx = 1; step();
    chk("R7 rx done clears", {7'b0, flags[2]}, 8'h00);
    // R3 error request and R10 priority over full
    s_ovr = 1; s_rxf = 1; sl_rx = 0; step(); step();
    chk("R3 rx error", {7'b0, r_err}, 8'h01);
    chk("R10 error highest", {4'b0, prio}, 8'h08);
    // R7 tx done clears both tx flags
    s_txe = 1; s_txend = 1; clr_stb = 1; clr_mask = 6'b111000; e_tx = 1; sl_tx = 1; step(); step();
    chk("R6 trig_tx", {7'b0, t_tx}, 8'h01);
    d_tx = 1; step();
    chk("R7 tx done clears bit0 bit1", {6'b0, flags[1:0]}, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      s_txe = ($urandom % 8) == 0; s_txend = ($urandom % 8) == 0;
      s_rxf = ($urandom % 8) == 0; s_ovr = ($urandom % 16) == 0;
      s_par = ($urandom % 16) == 0; s_frm = ($urandom % 16) == 0;
      clr_stb = ($urandom % 6) == 0; clr_mask = 6'($urandom);
      d_tx = ($urandom % 4) == 0; d_rx = ($urandom % 4) == 0;
      if (($urandom % 16) == 0) {e_tx, e_rx, e_te} = 3'($urandom);
      if (($urandom % 32) == 0) {sl_tx, sl_rx} = 2'($urandom);
      step();
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule